// File: doc/BRIEF.md
# Power Domain Sleep/Wake Sequencer

This always-on controller moves one switchable logic domain between a running state and a powered-off state. A power management unit or a software register raises a sleep or wake request, and the sequencer drives the domain-boundary controls in a fixed order. It drives the isolation enable, a one-cycle retention save strobe, a one-cycle retention restore strobe, a retention hold level and the switch enable. The switch enable goes to a separate ramp block that turns on the switch groups in stages and returns a power-good acknowledge.

Going down, the sequencer clamps the outputs first, then saves state, then opens the switches. Coming up, it closes the switches, waits for the acknowledge, restores state and only then releases the clamps. A programmable settle count spaces the steps. A programmable limit bounds the wait for the acknowledge. Access requests from the always-on side are granted only while the domain is fully active. The block reports a 3-bit status, a ready flag and an error flag. All control, status and access outputs come from flops.

Top module: `pdom_sequencer`

## Requirements
- R1: A sleep request sampled in the active state sets iso_en on that same clock edge. The ret_save pulse follows (N+1) cycles later, sw_en falls 2(N+1) cycles after the request edge, and the status reads sleep 3(N+1) cycles after it, where N is settle_cycles.
- R2: ret_save is high for exactly one cycle per power-down. ret_hold is high from that pulse through the whole sleep period and the wake-up, and falls only when the domain becomes active. Whenever sw_en is low, ret_hold is high.
- R3: Whenever sw_en is low, iso_en is high. iso_en falls only on the edge where the domain becomes active, and that edge comes after the acknowledge.
- R4: A wake request sampled in the sleep state raises sw_en on that edge. The edge that samples sw_ack high gives a one-cycle ret_restore pulse. (N+1) cycles after that edge, iso_en falls and ready rises.
- R5: ready is high only in the active state, which needs a prior acknowledge. An access_req sampled in the active state gives access_grant=1 on the next edge. Sampled in any other state, it gives access_deny=1 and access_grant=0.
- R6: While iso_en is high, iso_out[i] equals clamp_sel[i], where 0 clamps low and 1 clamps high. While iso_en is low, iso_out equals dom_out.
- R7: With settle_cycles=N, each timed step lasts N+1 cycles. N=0 gives a single-cycle step.
- R8: A sleep request sampled while waking is held. The domain first reaches the active state, with ready=1, and starts going down on the next edge.
- R9: If sw_ack stays low, the error state is entered on edge L+1 after the wake edge, where L is ack_limit. In that state err=1, iso_en=1, sw_en=0 and ready=0, and isolation stays asserted while err is set.
- R10: After reset the domain is taken as off: iso_en=1, ret_hold=1, sw_en=0, ready=0, err=0 and status sleep.
- R11: status encodes sleep=0, waking=1, active=2, going down=3 and error=4.
- R12: A sleep request in the sleep state and a wake request in the active state are ignored.
- R13: A wake request in the error state clears err and starts a new wake-up with sw_en=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sleep_req | input | 1 | Request to power the domain down |
| wake_req | input | 1 | Request to power the domain up |
| settle_cycles | input | SETTLE_W | Extra cycles N spent in each timed step |
| ack_limit | input | TMO_W | Cycles allowed for the acknowledge before the error state |
| clamp_sel | input | NOUT | Per-output clamp level used during isolation |
| dom_out | input | NOUT | Outputs of the switchable domain |
| sw_ack | input | 1 | Power-good acknowledge from the ramp block |
| access_req | input | 1 | Access attempt from the always-on side |
| iso_out | output | NOUT | Domain outputs after isolation clamping |
| iso_en | output | 1 | Isolation enable |
| ret_save | output | 1 | One-cycle retention save strobe |
| ret_restore | output | 1 | One-cycle retention restore strobe |
| ret_hold | output | 1 | Retention hold level |
| sw_en | output | 1 | Switch enable to the ramp block |
| status | output | 3 | Domain state code |
| ready | output | 1 | Domain usable |
| err | output | 1 | Acknowledge timeout flag |
| access_grant | output | 1 | Access accepted |
| access_deny | output | 1 | Access refused |

## Verification
The hardest case to reach is a sleep request that arrives part-way through a wake-up. The request has to land after the switches are enabled and before the restore step completes. It must then produce a full active cycle before the domain goes down again. The bench raises wake, pulses sleep one cycle later while sw_ack is held low, and then supplies the acknowledge. It checks that the active state is reached at the predicted cycle and that the next edge starts the power-down. The timeout path is forced by leaving sw_ack low and reading the error status on the exact expiry cycle and on the cycle before it. A table of settle counts, acknowledge delays and clamp patterns measures the cycle of every strobe edge.

// File: rtl/pds_pkg.sv
package pds_pkg;

   typedef enum logic [2:0] {
      ST_SLEEP   = 3'd0,
      ST_UP_SW   = 3'd1,
      ST_UP_RST  = 3'd2,
      ST_ACTIVE  = 3'd3,
      ST_DN_ISO  = 3'd4,
      ST_DN_SAVE = 3'd5,
      ST_DN_SW   = 3'd6,
      ST_FAULT   = 3'd7
   } pds_state_e;

   localparam logic [2:0] STAT_SLEEP      = 3'd0;
   localparam logic [2:0] STAT_WAKING     = 3'd1;
   localparam logic [2:0] STAT_ACTIVE     = 3'd2;
   localparam logic [2:0] STAT_GOING_DOWN = 3'd3;
   localparam logic [2:0] STAT_ERROR      = 3'd4;

   function automatic logic [2:0] status_of(pds_state_e s);
      case (s)
         ST_UP_SW, ST_UP_RST:              return STAT_WAKING;
         ST_ACTIVE:                        return STAT_ACTIVE;
         ST_DN_ISO, ST_DN_SAVE, ST_DN_SW:  return STAT_GOING_DOWN;
         ST_FAULT:                         return STAT_ERROR;
         default:                          return STAT_SLEEP;
      endcase
   endfunction

endpackage

// File: rtl/pds_step_timer.sv
module pds_step_timer #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         done
);
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (load)           cnt_q <= load_val;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign done = (cnt_q == '0);
endmodule

// File: rtl/pds_ack_watchdog.sv
module pds_ack_watchdog #(
   parameter int unsigned W = 12
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         run,
   input  logic         ack,
   input  logic [W-1:0] limit,
   output logic         expired
);
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               cnt_q <= '0;
      else if (!run || ack)     cnt_q <= '0;
      else if (cnt_q != limit)  cnt_q <= cnt_q + 1'b1;
   end

   assign expired = run && !ack && (cnt_q == limit);
endmodule

// File: rtl/pds_iso_clamp.sv
module pds_iso_clamp #(
   parameter int unsigned N = 4
) (
   input  logic         iso_en,
   input  logic [N-1:0] level,
   input  logic [N-1:0] din,
   output logic [N-1:0] dout
);
   for (genvar i = 0; i < N; i++) begin : g_bit
      assign dout[i] = iso_en ? level[i] : din[i];
   end
endmodule

// File: rtl/pdom_sequencer.sv
module pdom_sequencer
   import pds_pkg::*;
#(
   parameter int unsigned NOUT     = 4,
   parameter int unsigned SETTLE_W = 8,
   parameter int unsigned TMO_W    = 12
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                sleep_req,
   input  logic                wake_req,
   input  logic [SETTLE_W-1:0] settle_cycles,
   input  logic [TMO_W-1:0]    ack_limit,
   input  logic [NOUT-1:0]     clamp_sel,
   input  logic [NOUT-1:0]     dom_out,
   input  logic                sw_ack,
   input  logic                access_req,
   output logic [NOUT-1:0]     iso_out,
   output logic                iso_en,
   output logic                ret_save,
   output logic                ret_restore,
   output logic                ret_hold,
   output logic                sw_en,
   output logic [2:0]          status,
   output logic                ready,
   output logic                err,
   output logic                access_grant,
   output logic                access_deny
);
   if (NOUT < 1) begin : g_bad_nout
      $error("pdom_sequencer: NOUT must be at least 1");
   end
   if (SETTLE_W < 1 || SETTLE_W > 16) begin : g_bad_settle
      $error("pdom_sequencer: SETTLE_W must be 1..16");
   end
   if (TMO_W < 2 || TMO_W > 24) begin : g_bad_tmo
      $error("pdom_sequencer: TMO_W must be 2..24");
   end

   pds_state_e state_q, state_nx;
   logic       step_done;
   logic       ack_expired;
   logic       sleep_pend_q;
   logic       waking;

   assign waking = (state_q == ST_UP_SW) || (state_q == ST_UP_RST);

   pds_step_timer #(.W(SETTLE_W)) u_step (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (state_nx != state_q),
      .load_val (settle_cycles),
      .done     (step_done)
   );

   pds_ack_watchdog #(.W(TMO_W)) u_wdog (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (state_q == ST_UP_SW),
      .ack     (sw_ack),
      .limit   (ack_limit),
      .expired (ack_expired)
   );

   always_comb begin
      state_nx = state_q;
      case (state_q)
         ST_SLEEP:   if (wake_req) state_nx = ST_UP_SW;
         ST_UP_SW: begin
            if (sw_ack)           state_nx = ST_UP_RST;
            else if (ack_expired) state_nx = ST_FAULT;
         end
         ST_UP_RST:  if (step_done) state_nx = ST_ACTIVE;
         ST_ACTIVE:  if (sleep_req || sleep_pend_q) state_nx = ST_DN_ISO;
         ST_DN_ISO:  if (step_done) state_nx = ST_DN_SAVE;
         ST_DN_SAVE: if (step_done) state_nx = ST_DN_SW;
         ST_DN_SW:   if (step_done) state_nx = ST_SLEEP;
         ST_FAULT:   if (wake_req) state_nx = ST_UP_SW;
         default:    state_nx = ST_SLEEP;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sleep_pend_q <= 1'b0;
      end else if (state_q == ST_ACTIVE || state_nx == ST_FAULT) begin
         sleep_pend_q <= 1'b0;
      end else if (sleep_req && waking) begin
         sleep_pend_q <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q      <= ST_SLEEP;
         iso_en       <= 1'b1;
         ret_hold     <= 1'b1;
         sw_en        <= 1'b0;
         ret_save     <= 1'b0;
         ret_restore  <= 1'b0;
         status       <= STAT_SLEEP;
         ready        <= 1'b0;
         err          <= 1'b0;
         access_grant <= 1'b0;
         access_deny  <= 1'b0;
      end else begin
         state_q      <= state_nx;
         iso_en       <= (state_nx != ST_ACTIVE);
         ret_hold     <= !((state_nx == ST_ACTIVE) || (state_nx == ST_DN_ISO));
         sw_en        <= (state_nx == ST_UP_SW)  || (state_nx == ST_UP_RST) ||
                         (state_nx == ST_ACTIVE) || (state_nx == ST_DN_ISO) ||
                         (state_nx == ST_DN_SAVE);
         ret_save     <= (state_nx == ST_DN_SAVE) && (state_q != ST_DN_SAVE);
         ret_restore  <= (state_nx == ST_UP_RST) && (state_q != ST_UP_RST);
         status       <= status_of(state_nx);
         ready        <= (state_nx == ST_ACTIVE);
         err          <= (state_nx == ST_FAULT);
         access_grant <= access_req && (state_q == ST_ACTIVE);
         access_deny  <= access_req && (state_q != ST_ACTIVE);
      end
   end

   pds_iso_clamp #(.N(NOUT)) u_clamp (
      .iso_en (iso_en),
      .level  (clamp_sel),
      .din    (dom_out),
      .dout   (iso_out)
   );
endmodule

// File: rtl/pds_seq_checker.sv
module pds_seq_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       iso_en,
   input logic       ret_save,
   input logic       ret_restore,
   input logic       ret_hold,
   input logic       sw_en,
   input logic       sw_ack,
   input logic [2:0] status,
   input logic       ready,
   input logic       err,
   input logic       access_grant
);
   p_iso_when_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !sw_en |-> iso_en);

   p_hold_when_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !sw_en |-> ret_hold);

   p_save_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ret_save |=> !ret_save);

   p_switch_off_order_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sw_en) |-> (iso_en && ret_hold));

   p_restore_after_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ret_restore) |-> $past(sw_ack));

   p_ready_powered_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> (sw_en && !iso_en && !err));

   p_grant_when_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
      access_grant |-> $past(ready));

   p_err_isolated_r9: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> (iso_en && !ready && !sw_en));

   p_status_legal_r11: assert property (@(posedge clk) disable iff (!rst_n)
      status <= 3'd4);
endmodule

bind pdom_sequencer pds_seq_checker u_pds_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .iso_en       (iso_en),
   .ret_save     (ret_save),
   .ret_restore  (ret_restore),
   .ret_hold     (ret_hold),
   .sw_en        (sw_en),
   .sw_ack       (sw_ack),
   .status       (status),
   .ready        (ready),
   .err          (err),
   .access_grant (access_grant)
);

// File: tb/pdom_sequencer_tb.sv
module pdom_sequencer_tb;
   localparam int NOUT = 4;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            sleep_req = 1'b0;
   logic            wake_req = 1'b0;
   logic [7:0]      settle_cycles = 8'd0;
   logic [11:0]     ack_limit = 12'd8;
   logic [NOUT-1:0] clamp_sel = 4'b0101;
   logic [NOUT-1:0] dom_out = 4'b0011;
   logic            sw_ack = 1'b0;
   logic            access_req = 1'b0;
   logic [NOUT-1:0] iso_out;
   logic            iso_en, ret_save, ret_restore, ret_hold, sw_en;
   logic [2:0]      status;
   logic            ready, err, access_grant, access_deny;

   pdom_sequencer #(.NOUT(NOUT), .SETTLE_W(8), .TMO_W(12)) u_dut (
      .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .wake_req(wake_req),
      .settle_cycles(settle_cycles), .ack_limit(ack_limit), .clamp_sel(clamp_sel),
      .dom_out(dom_out), .sw_ack(sw_ack), .access_req(access_req),
      .iso_out(iso_out), .iso_en(iso_en), .ret_save(ret_save),
      .ret_restore(ret_restore), .ret_hold(ret_hold), .sw_en(sw_en),
      .status(status), .ready(ready), .err(err),
      .access_grant(access_grant), .access_deny(access_deny)
   );

   always #5 clk = ~clk;

   // status codes per R11
   localparam logic [2:0] S_SLEEP = 3'd0, S_WAKE = 3'd1, S_ACT = 3'd2,
                          S_DOWN = 3'd3, S_ERR = 3'd4;

   // vector: settle[15:12], ack delay[11:8], clamp[7:4], dom[3:0]
   localparam int NVEC = 4;
   localparam logic [15:0] VEC [NVEC] = '{
      16'h0_0_5_A, 16'h1_2_F_0, 16'h3_1_0_F, 16'h2_5_9_6
   };

   int n_checks = 0, n_errors = 0;
   int cyc = 0;
   bit finished = 0;
   int t_iso_on, t_iso_off, t_save, t_rest, t_sw_on, t_sw_off, t_rdy, t_slp;
   int n_save, n_rest;
   logic p_iso = 1'b1, p_sw = 1'b0, p_rdy = 1'b0;
   logic [2:0] p_stat = 3'd0;

   task automatic chk(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_errors++;
         $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   task automatic tick();
      @(posedge clk); #1;
      cyc++;
      if (!sw_en) sw_ack = 1'b0;
      if (iso_en && !p_iso)  t_iso_on  = cyc;
      if (!iso_en && p_iso)  t_iso_off = cyc;
      if (sw_en && !p_sw)    t_sw_on   = cyc;
      if (!sw_en && p_sw)    t_sw_off  = cyc;
      if (ready && !p_rdy)   t_rdy     = cyc;
      if (status == S_SLEEP && p_stat != S_SLEEP) t_slp = cyc;
      if (ret_save)    begin n_save++; t_save = cyc; end
      if (ret_restore) begin n_rest++; t_rest = cyc; end
      if (!sw_en && !iso_en) chk("R3 iso while switches off", 0, 1);
      if (!sw_en && !ret_hold) chk("R2 hold while switches off", 0, 1);
      p_iso = iso_en; p_sw = sw_en; p_rdy = ready; p_stat = status;
   endtask

   task automatic go_active(input int dly);
      wake_req = 1'b1; tick(); wake_req = 1'b0;
      repeat (dly) tick();
      sw_ack = 1'b1;
      for (int k = 0; k < 60 && !ready; k++) tick();
   endtask

   task automatic go_sleep();
      sleep_req = 1'b1; tick(); sleep_req = 1'b0;
      for (int k = 0; k < 80 && status != S_SLEEP; k++) tick();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_checks++; n_errors++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end

   initial begin
      int a, w, k, n, d;
      logic [3:0] c, dv;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      tick();
      // R10 reset state
      chk("R10 iso_en", iso_en, 1);
      chk("R10 ret_hold", ret_hold, 1);
      chk("R10 sw_en", sw_en, 0);
      chk("R10 ready", ready, 0);
      chk("R10 err", err, 0);
      chk("R10 status", status, S_SLEEP);
      chk("R6 clamp after reset", iso_out, clamp_sel);

      // R12 sleep in sleep ignored; R5 access denied
      sleep_req = 1'b1; access_req = 1'b1; tick(); sleep_req = 1'b0; access_req = 1'b0;
      chk("R12 sleep ignored status", status, S_SLEEP);
      chk("R12 sleep ignored sw_en", sw_en, 0);
      chk("R5 deny in sleep", access_deny, 1);
      chk("R5 no grant in sleep", access_grant, 0);

      // R9 timeout with limit 5
      ack_limit = 12'd5;
      wake_req = 1'b1; tick(); wake_req = 1'b0; w = cyc;
      chk("R4 sw_en on wake edge", sw_en, 1);
      chk("R11 waking code", status, S_WAKE);
      access_req = 1'b1; tick(); access_req = 1'b0;
      chk("R5 deny while waking", access_deny, 1);
      repeat (4) tick();
      chk("R9 no error before limit", err, 0);
      chk("R9 still waking at W+L", status, S_WAKE);
      tick();
      chk("R9 error at W+L+1", err, 1);
      chk("R11 error code", status, S_ERR);
      chk("R9 switches off on error", sw_en, 0);
      chk("R9 isolation on error", iso_en, 1);
      repeat (3) tick();
      chk("R9 error held", err, 1);
      chk("R9 isolation held", iso_en, 1);

      // R13 recovery
      ack_limit = 12'd8;
      wake_req = 1'b1; tick(); wake_req = 1'b0;
      chk("R13 err cleared", err, 0);
      chk("R13 sw_en on retry", sw_en, 1);
      sw_ack = 1'b1;
      for (int j = 0; j < 20 && !ready; j++) tick();
      chk("R13 active after retry", status, S_ACT);

      // R12 wake in active ignored; R5 grant
      wake_req = 1'b1; access_req = 1'b1; tick(); wake_req = 1'b0; access_req = 1'b0;
      chk("R12 wake ignored status", status, S_ACT);
      chk("R12 wake ignored iso", iso_en, 0);
      chk("R5 grant in active", access_grant, 1);
      chk("R5 no deny in active", access_deny, 0);

      // table walk: R1 R2 R3 R4 R6 R7
      for (int v = 0; v < NVEC; v++) begin
         n  = VEC[v][15:12];
         d  = VEC[v][11:8];
         c  = VEC[v][7:4];
         dv = VEC[v][3:0];
         settle_cycles = 8'(n);
         clamp_sel = c; dom_out = dv;
         n_save = 0; n_rest = 0;
         tick();
         chk("R6 pass-through active", iso_out, dv);
         sleep_req = 1'b1; tick(); sleep_req = 1'b0; a = cyc;
         chk("R1 iso on request edge", t_iso_on, a);
         chk("R11 going-down code", status, S_DOWN);
         chk("R6 clamp pattern", iso_out, c);
         for (int j = 0; j < 80 && status != S_SLEEP; j++) tick();
         chk("R1 save cycle", t_save, a + n + 1);
         chk("R2 single save pulse", n_save, 1);
         chk("R1 switch-off cycle", t_sw_off, a + 2*n + 2);
         chk("R7 sleep cycle", t_slp, a + 3*n + 3);
         chk("R2 hold in sleep", ret_hold, 1);
         dom_out = ~dv; tick();
         chk("R6 clamp ignores domain", iso_out, c);
         dom_out = dv;
         wake_req = 1'b1; tick(); wake_req = 1'b0; w = cyc;
         chk("R4 switch-on cycle", t_sw_on, w);
         repeat (d) tick();
         chk("R5 not ready before ack", ready, 0);
         chk("R3 iso before ack", iso_en, 1);
         sw_ack = 1'b1; tick(); k = cyc;
         chk("R4 restore cycle", t_rest, k);
         for (int j = 0; j < 80 && !ready; j++) tick();
         chk("R2 single restore pulse", n_rest, 1);
         chk("R4 ready cycle", t_rdy, k + n + 1);
         chk("R3 iso release cycle", t_iso_off, k + n + 1);
         chk("R2 hold released", ret_hold, 0);
         chk("R6 pass-through after wake", iso_out, dv);
      end

      // R8 sleep during wake-up, settle 1
      settle_cycles = 8'd1;
      go_sleep();
      wake_req = 1'b1; tick(); wake_req = 1'b0;
      sleep_req = 1'b1; tick(); sleep_req = 1'b0;
      chk("R8 still waking", status, S_WAKE);
      sw_ack = 1'b1; tick();
      repeat (2) tick();
      chk("R8 reaches active", status, S_ACT);
      chk("R8 ready set", ready, 1);
      tick();
      chk("R8 pending sleep serviced", status, S_DOWN);
      for (int j = 0; j < 40 && status != S_SLEEP; j++) tick();
      chk("R8 ends in sleep", status, S_SLEEP);

      // R7 zero settle back-to-back steps
      settle_cycles = 8'd0;
      go_active(0);
      n_save = 0;
      sleep_req = 1'b1; tick(); sleep_req = 1'b0; a = cyc;
      tick();
      chk("R7 single-cycle save step", ret_save, 1);
      tick();
      chk("R7 single-cycle switch-off", sw_en, 0);

      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end
endmodule